// File: doc/BRIEF.md
# Bit and Block Error Statistics Unit

This unit sits at the end of a forward error correction test path and scores the link. Each clock beat carries three aligned 128-bit words: the reference information word, the hard-decision word received before decoding, and the word produced by the decoder. For both received streams it adds up the number of differing bits, and it also counts the blocks that contain at least one differing bit. Per block it adds the decoder's reported iteration count into a running total.

Software programs the block length, an optional coded length, the number of blocks to score and a tail mask through a small word-addressed register port, then writes the start bit. The unit counts beats into blocks and applies the tail mask to the final beat of each block. It stops scoring after the programmed number of blocks and raises idle. Software then reads the counters. One-cycle flags mark each finished block and tell whether that block was in error on each stream.

Top module: `err_stat_top`

## Requirements
- R1: After reset the unit is idle (CTRL address 0 reads bit0 = 1), the parity-select flag (CTRL bit1) reads 0, and every counter reads 0.
- R2: A write to CTRL with bit0 = 1 clears all counters on the next edge and starts a run. idle falls if the block count register (address 1) is non-zero. If it is zero, the unit stays idle.
- R3: For every accepted beat, each stream's bit counter grows by the number of set bits in (reference XOR received). Every beat other than the final beat of a block counts all 128 bits.
- R4: On the final beat, only bits set in the tail mask count. The tail mask is formed from four registers at addresses 4..7, where address 4+j holds mask bits 32j+31..32j. When the active length is a multiple of 128, all 128 bits count and the mask is ignored.
- R5: A block adds one to a stream's block counter when any masked bit of any of its beats differs. blk_done_o pulses in the cycle after the final beat is accepted, together with raw_blk_err_o / cor_blk_err_o for that block.
- R6: The raw counters (bits at address 10, blocks at 11) and the corrected counters (bits at address 8, blocks at 9) count independently of each other.
- R7: A block spans ceil(L/128) beats. L is the K register (address 2), or the N register (address 3) when CTRL bit1 is set.
- R8: The iteration total (address 13) adds iter_i as sampled on each block's final beat. The scored-block count reads at address 12.
- R9: After the programmed number of blocks the unit returns to idle. While idle, beats change no counter and raise no flag.
- R10: Every counter saturates at its all-ones value instead of wrapping.
- R11: The configuration registers (block count, K, N) read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| beat_valid_i | input | 1 | The three data words are valid this cycle |
| ref_data_i | input | 128 | Reference information word |
| raw_data_i | input | 128 | Hard-decision word taken before decoding |
| cor_data_i | input | 128 | Word produced by the decoder |
| iter_i | input | 8 | Decoder iteration count, used on a block's final beat |
| raw_blk_err_o | output | 1 | Finished block had errors on the raw stream |
| cor_blk_err_o | output | 1 | Finished block had errors on the decoded stream |
| blk_done_o | output | 1 | One block finished scoring |
| idle_o | output | 1 | No run in progress |

## Verification
Some properties are checked on every cycle. Counters are cleared by start and never decrease between starts. Nothing moves while the unit is idle. Block-error flags only appear with blk_done_o, and each one matches a one-step increment of its counter or a saturated counter. Other behaviour can only be shown by the bench's scenarios: the exact bit counts, tail masking against a non-multiple length, the mask override for whole-word lengths, the selection between K and N, the iteration total, and saturation.

// File: rtl/err_stat_pkg.sv
package err_stat_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] ADR_CTRL     = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_NBLK     = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_KLEN     = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_NLEN     = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_MASK0    = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_COR_BITS = 4'd8;
  localparam logic [ADDR_W-1:0] ADR_COR_BLKS = 4'd9;
  localparam logic [ADDR_W-1:0] ADR_RAW_BITS = 4'd10;
  localparam logic [ADDR_W-1:0] ADR_RAW_BLKS = 4'd11;
  localparam logic [ADDR_W-1:0] ADR_BLOCKS   = 4'd12;
  localparam logic [ADDR_W-1:0] ADR_ITERS    = 4'd13;
  localparam int CTRL_START = 0;
  localparam int CTRL_PAR   = 1;
endpackage

// File: rtl/err_stat_regs.sv
module err_stat_regs
  import err_stat_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int DATA_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic              start_o,
  output logic              par_sel_o,
  output logic [REG_W-1:0]  nblk_o,
  output logic [REG_W-1:0]  klen_o,
  output logic [REG_W-1:0]  nlen_o,
  output logic [DATA_W-1:0] mask_o
);
  localparam int MASK_WORDS = DATA_W / REG_W;

  logic [REG_W-1:0] mask_q [MASK_WORDS];

  assign start_o = we_i && (addr_i == ADR_CTRL) && wdata_i[CTRL_START];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_sel_o <= 1'b0;
      nblk_o    <= '0;
      klen_o    <= '0;
      nlen_o    <= '0;
      for (int w = 0; w < MASK_WORDS; w++) mask_q[w] <= '1;
    end else if (we_i) begin
      if (addr_i == ADR_CTRL) par_sel_o <= wdata_i[CTRL_PAR];
      if (addr_i == ADR_NBLK) nblk_o <= wdata_i;
      if (addr_i == ADR_KLEN) klen_o <= wdata_i;
      if (addr_i == ADR_NLEN) nlen_o <= wdata_i;
      for (int w = 0; w < MASK_WORDS; w++)
        if (addr_i == ADDR_W'(int'(ADR_MASK0) + w)) mask_q[w] <= wdata_i;
    end
  end

  for (genvar g = 0; g < MASK_WORDS; g++) begin : g_mask
    assign mask_o[g*REG_W +: REG_W] = mask_q[g];
  end
endmodule

// File: rtl/err_stat_seq.sv
module err_stat_seq #(
  parameter int REG_W  = 32,
  parameter int DATA_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [REG_W-1:0] nblk_i,
  input  logic [REG_W-1:0] len_i,
  input  logic             valid_i,
  output logic             fire_o,
  output logic             last_o,
  output logic             partial_o,
  output logic             blk_end_o,
  output logic [REG_W-1:0] blocks_o,
  output logic             idle_o
);
  localparam int LOG_W = $clog2(DATA_W);

  logic [REG_W-1:0] beats, beat_q;
  logic             run_q;

  always_comb begin
    partial_o = |len_i[LOG_W-1:0];
    beats     = (len_i >> LOG_W) + REG_W'(partial_o);
    if (beats == '0) beats = REG_W'(1);
  end

  assign last_o = (beat_q == beats - REG_W'(1));
  assign fire_o = valid_i && run_q && !start_i;
  assign idle_o = !run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      beat_q    <= '0;
      blocks_o  <= '0;
      blk_end_o <= 1'b0;
    end else if (start_i) begin
      run_q     <= (nblk_i != '0);
      beat_q    <= '0;
      blocks_o  <= '0;
      blk_end_o <= 1'b0;
    end else begin
      blk_end_o <= fire_o && last_o;
      if (fire_o) begin
        if (last_o) begin
          beat_q   <= '0;
          blocks_o <= blocks_o + REG_W'(1);
          if (blocks_o + REG_W'(1) == nblk_i) run_q <= 1'b0;
        end else begin
          beat_q <= beat_q + REG_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/err_stat_lane.sv
module err_stat_lane #(
  parameter int DATA_W = 128,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              fire_i,
  input  logic              last_i,
  input  logic              partial_i,
  input  logic [DATA_W-1:0] ref_i,
  input  logic [DATA_W-1:0] rx_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [CNT_W-1:0]  bits_o,
  output logic [CNT_W-1:0]  blks_o,
  output logic              blk_err_o
);
  localparam int PC_W = $clog2(DATA_W) + 1;

  logic [DATA_W-1:0] diff;
  logic [PC_W-1:0]   pc;
  logic [CNT_W:0]    bit_sum, blk_sum;
  logic              seen_q, hit;

  always_comb begin
    diff = ref_i ^ rx_i;
    if (last_i && partial_i) diff = diff & mask_i;
    pc = '0;
    for (int i = 0; i < DATA_W; i++) pc = pc + PC_W'(diff[i]);
    hit     = seen_q || (|diff);
    bit_sum = {1'b0, bits_o} + (CNT_W+1)'(pc);
    blk_sum = {1'b0, blks_o} + (CNT_W+1)'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_o    <= '0;
      blks_o    <= '0;
      seen_q    <= 1'b0;
      blk_err_o <= 1'b0;
    end else if (start_i) begin
      bits_o    <= '0;
      blks_o    <= '0;
      seen_q    <= 1'b0;
      blk_err_o <= 1'b0;
    end else begin
      blk_err_o <= fire_i && last_i && hit;
      if (fire_i) begin
        bits_o <= bit_sum[CNT_W] ? '1 : bit_sum[CNT_W-1:0];
        if (last_i) begin
          seen_q <= 1'b0;
          if (hit) blks_o <= blk_sum[CNT_W] ? '1 : blk_sum[CNT_W-1:0];
        end else begin
          seen_q <= hit;
        end
      end
    end
  end
endmodule

// File: rtl/err_stat_top.sv
module err_stat_top
  import err_stat_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int DATA_W = 128,
  parameter int CNT_W  = 32,
  parameter int ITER_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              beat_valid_i,
  input  logic [127:0]      ref_data_i,
  input  logic [127:0]      raw_data_i,
  input  logic [127:0]      cor_data_i,
  input  logic [7:0]        iter_i,
  output logic              raw_blk_err_o,
  output logic              cor_blk_err_o,
  output logic              blk_done_o,
  output logic              idle_o
);
  localparam int NSTREAM = 2; // 0 = raw, 1 = corrected

  logic              start, par_sel, fire, last, partial;
  logic [REG_W-1:0]  nblk, klen, nlen, blocks;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] rx      [NSTREAM];
  logic [CNT_W-1:0]  bits    [NSTREAM];
  logic [CNT_W-1:0]  blks    [NSTREAM];
  logic              blk_err [NSTREAM];
  logic [CNT_W-1:0]  iter_q;
  logic [CNT_W:0]    iter_sum;

  err_stat_regs #(.REG_W(REG_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .start_o(start), .par_sel_o(par_sel), .nblk_o(nblk), .klen_o(klen),
    .nlen_o(nlen), .mask_o(mask)
  );

  err_stat_seq #(.REG_W(REG_W), .DATA_W(DATA_W)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .nblk_i(nblk),
    .len_i(par_sel ? nlen : klen), .valid_i(beat_valid_i),
    .fire_o(fire), .last_o(last), .partial_o(partial),
    .blk_end_o(blk_done_o), .blocks_o(blocks), .idle_o(idle_o)
  );

  assign rx[0] = raw_data_i;
  assign rx[1] = cor_data_i;

  for (genvar s = 0; s < NSTREAM; s++) begin : g_lane
    err_stat_lane #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_lane (
      .clk_i, .rst_ni, .start_i(start), .fire_i(fire), .last_i(last),
      .partial_i(partial), .ref_i(ref_data_i), .rx_i(rx[s]), .mask_i(mask),
      .bits_o(bits[s]), .blks_o(blks[s]), .blk_err_o(blk_err[s])
    );
  end

  assign raw_blk_err_o = blk_err[0];
  assign cor_blk_err_o = blk_err[1];

  assign iter_sum = {1'b0, iter_q} + (CNT_W+1)'(iter_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              iter_q <= '0;
    else if (start)           iter_q <= '0;
    else if (fire && last)    iter_q <= iter_sum[CNT_W] ? '1 : iter_sum[CNT_W-1:0];
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADR_CTRL:     reg_rdata_o = 32'({par_sel, idle_o});
      ADR_NBLK:     reg_rdata_o = nblk;
      ADR_KLEN:     reg_rdata_o = klen;
      ADR_NLEN:     reg_rdata_o = nlen;
      ADR_COR_BITS: reg_rdata_o = 32'(bits[1]);
      ADR_COR_BLKS: reg_rdata_o = 32'(blks[1]);
      ADR_RAW_BITS: reg_rdata_o = 32'(bits[0]);
      ADR_RAW_BLKS: reg_rdata_o = 32'(blks[0]);
      ADR_BLOCKS:   reg_rdata_o = blocks;
      ADR_ITERS:    reg_rdata_o = 32'(iter_q);
      default: begin
        for (int w = 0; w < DATA_W / REG_W; w++)
          if (reg_addr_i == 4'(int'(ADR_MASK0) + w)) reg_rdata_o = mask[w*REG_W +: REG_W];
      end
    endcase
  end
endmodule

// File: rtl/err_stat_chk.sv
module err_stat_chk #(
  parameter int CNT_W = 32,
  parameter int REG_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start,
  input logic             idle,
  input logic             done,
  input logic             raw_err,
  input logic             cor_err,
  input logic [CNT_W-1:0] raw_bits,
  input logic [CNT_W-1:0] cor_bits,
  input logic [CNT_W-1:0] raw_blks,
  input logic [CNT_W-1:0] cor_blks,
  input logic [REG_W-1:0] blocks
);
  p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (raw_bits == '0 && cor_bits == '0 && raw_blks == '0 && cor_blks == '0 && blocks == '0));

  p_no_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start |=> (raw_bits >= $past(raw_bits) && cor_bits >= $past(cor_bits)
                && raw_blks >= $past(raw_blks) && cor_blks >= $past(cor_blks)));

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && !start) |=> ($stable(raw_bits) && $stable(cor_bits) && $stable(blocks)));

  p_done_from_run_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> $past(!idle));

  p_flag_with_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_err || cor_err) |-> done);

  p_raw_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_err |-> (raw_blks == $past(raw_blks) + 1'b1 || raw_blks == '1));

  p_cor_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cor_err |-> (cor_blks == $past(cor_blks) + 1'b1 || cor_blks == '1));
endmodule

bind err_stat_top err_stat_chk #(.CNT_W(CNT_W), .REG_W(REG_W)) u_chk (
  .clk_i, .rst_ni, .start(start), .idle(idle_o), .done(blk_done_o),
  .raw_err(raw_blk_err_o), .cor_err(cor_blk_err_o),
  .raw_bits(bits[0]), .cor_bits(bits[1]), .raw_blks(blks[0]), .cor_blks(blks[1]),
  .blocks(blocks)
);

// File: tb/err_stat_top_tb_top.sv
`timescale 1ns/1ps
module err_stat_top_tb_top;
  localparam int CNT_W = 12;
  localparam logic [31:0] CMAX = 32'((1 << CNT_W) - 1);
  localparam int NV = 6;
  localparam int KLEN = 200;
  // scenario table: error patterns per beat, two beats per block
  localparam logic [127:0] RAW_T [NV] = '{128'hF, (128'd1 << 100) | 128'h8, {128{1'b1}},
                                          128'h0, 128'h0, 128'h0};
  localparam logic [127:0] COR_T [NV] = '{128'h0, 128'h0, 128'd1 << 127,
                                          128'd1 << 80, 128'h0, 128'd1 << 71};
  localparam logic [7:0]   ITR_T [NV] = '{8'd5, 8'd5, 8'd12, 8'd12, 8'd3, 8'd3};

  logic clk = 0, rst_n = 0;
  logic we = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic valid = 0;
  logic [127:0] refw = 0, raww = 0, corw = 0;
  logic [7:0] iter = 0;
  logic raw_err, cor_err, done, idle;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  err_stat_top #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .beat_valid_i(valid),
    .ref_data_i(refw), .raw_data_i(raww), .cor_data_i(corw), .iter_i(iter),
    .raw_blk_err_o(raw_err), .cor_blk_err_o(cor_err), .blk_done_o(done), .idle_o(idle)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(posedge clk); #1; we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic beat(input logic [127:0] r, input logic [127:0] re, input logic [127:0] ce,
                      input logic [7:0] it);
    @(negedge clk); valid = 1; refw = r; raww = r ^ re; corw = r ^ ce; iter = it;
    @(posedge clk); #1; valid = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [127:0] tmask, m, pat;
    int e_rbits, e_cbits, e_rblk, e_cblk, e_iter;
    logic hr, hc;

    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1 reset state
    rd(4'd0, d);  check("R1 ctrl idle/parity", d, 32'h1);
    rd(4'd10, d); check("R1 raw bits", d, 0);
    rd(4'd8, d);  check("R1 cor bits", d, 0);
    rd(4'd13, d); check("R1 iter total", d, 0);

    // R11 readback
    wr(4'd1, 3); wr(4'd2, KLEN); wr(4'd3, 32'd300);
    rd(4'd1, d); check("R11 nblk", d, 3);
    rd(4'd2, d); check("R11 k", d, KLEN);
    rd(4'd3, d); check("R11 n", d, 300);

    // R4 tail mask for k=200: low 72 bits
    tmask = {128{1'b1}} >> (128 - (KLEN % 128));
    for (int j = 0; j < 4; j++) wr(4'(4 + j), tmask[32*j +: 32]);

    // R2 start
    wr(4'd0, 1);
    check("R2 idle falls", idle, 0);

    e_rbits = 0; e_cbits = 0; e_rblk = 0; e_cblk = 0; e_iter = 0; hr = 0; hc = 0;
    for (int i = 0; i < NV; i++) begin
      pat = {4{32'hA5C3_0F96}} ^ (128'(i) * 128'h1_0001_0001);
      beat(pat, RAW_T[i], COR_T[i], ITR_T[i]);
      m = (i % 2 == 1) ? tmask : {128{1'b1}};
      e_rbits += $countones(RAW_T[i] & m);
      e_cbits += $countones(COR_T[i] & m);
      hr |= |(RAW_T[i] & m);
      hc |= |(COR_T[i] & m);
      if (i % 2 == 1) begin
        check("R5 blk_done", done, 1);
        check("R5 raw flag", raw_err, hr);
        check("R6 cor flag", cor_err, hc);
        e_rblk += int'(hr); e_cblk += int'(hc); e_iter += ITR_T[i];
        hr = 0; hc = 0;
      end else begin
        check("R7 no done mid-block", done, 0);
      end
    end
    rd(4'd10, d); check("R3 raw bits", d, e_rbits);
    rd(4'd8, d);  check("R4 cor bits masked", d, e_cbits);
    rd(4'd11, d); check("R5 raw blocks", d, e_rblk);
    rd(4'd9, d);  check("R6 cor blocks", d, e_cblk);
    rd(4'd12, d); check("R8 blocks", d, 3);
    rd(4'd13, d); check("R8 iter total", d, e_iter);
    check("R9 idle after run", idle, 1);

    // R9 beats ignored while idle
    beat(128'h0, {128{1'b1}}, {128{1'b1}}, 8'd9);
    check("R9 no flag idle", done, 0);
    rd(4'd10, d); check("R9 raw unchanged", d, e_rbits);
    rd(4'd13, d); check("R9 iter unchanged", d, e_iter);

    // R2 start with zero blocks clears, stays idle
    wr(4'd1, 0); wr(4'd0, 1);
    check("R2 zero count idle", idle, 1);
    rd(4'd10, d); check("R2 cleared raw", d, 0);
    rd(4'd9, d);  check("R2 cleared cor blk", d, 0);

    // R7 parity select: n=300 -> 3 beats
    wr(4'd1, 1); wr(4'd0, 32'h3);
    rd(4'd0, d); check("R7 parity flag", d, 32'h2);
    beat(128'h0, 128'h0, 128'h0, 8'd1);
    beat(128'h0, 128'h0, 128'h0, 8'd1);
    check("R7 still running", idle, 0);
    beat(128'h0, 128'h0, 128'h0, 8'd1);
    check("R7 done after 3", done, 1);
    rd(4'd12, d); check("R7 blocks", d, 1);

    // R4 whole-word length ignores mask
    wr(4'd0, 0);
    for (int j = 0; j < 4; j++) wr(4'(4 + j), 0);
    wr(4'd2, 256); wr(4'd0, 1);
    beat(128'h0, {128{1'b1}}, 128'h0, 8'd0);
    beat(128'h0, {128{1'b1}}, 128'h1, 8'd0);
    rd(4'd10, d); check("R4 full last word raw", d, 256);
    rd(4'd8, d);  check("R4 full last word cor", d, 1);

    // R10 saturation: 40 all-ones beats
    wr(4'd2, 128 * 40); wr(4'd0, 1);
    for (int i = 0; i < 40; i++) beat(128'h0, {128{1'b1}}, 128'h0, 8'd200);
    rd(4'd10, d); check("R10 raw bits sat", d, CMAX);
    rd(4'd8, d);  check("R6 cor untouched", d, 0);
    rd(4'd11, d); check("R10 raw blocks", d, 1);
    check("R9 idle end", idle, 1);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule